// File: doc/BRIEF.md
# Pipelined Burst Memory with Clock-Enable Stall

A synchronous single-port word memory with a registered command stage and a registered read-data stage. Every control, address, byte-enable and write-data input is sampled on the rising clock edge. A command is taken in one enabled cycle (the address cycle). Write data for that command is taken in the following enabled cycle. Read data comes out of the output register in that same following cycle. Because of this fixed one-stage offset, reads and writes can follow each other in any order on every cycle, with no idle cycle between them.

A load cycle sets up a new access: a read, a write, or a deselect when the three chip enables do not select the device. An advance cycle repeats the access type that is in flight on the next address of a four-word burst. The two low address bits step either linearly or in interleaved (XOR) order, as chosen by a mode input that is captured on the load cycle. When the clock enable is low, the whole pipeline freezes: no register changes and no write is committed.

The controller is a three-state machine holding the access type in flight. The states are `ST_DESEL` (nothing in flight), `ST_READ` and `ST_WRITE`. The transitions are:
- LOAD_READ: load with the device selected and `wr_n` high.
- LOAD_WRITE: load with the device selected and `wr_n` low.
- LOAD_DESEL: load without selection. This transition can be taken from any state.
- ADVANCE: self-loop on the current state, with the burst step incremented.
- STALL: `clk_en` low, so nothing changes.

The array depth is set by `AW`. The full-size part uses `AW = 16`, which gives 65536 words of 32 bits. The default is a small depth for elaboration.

Top module: `pbsram_top`

## Requirements
- R1: While `rst_n` is low and after its release, until a read completes, `rvalid` is 0 and `rdata` is 0. Whenever `rvalid` is 0, `rdata` is 0.
- R2: A load read at enabled edge E (`adv_load`=0, device selected, `wr_n`=1) makes `rvalid`=1 and `rdata` equal to the addressed word just after the next enabled edge.
- R3: A load write at enabled edge E stores the `wdata` sampled at the next enabled edge. Only lane i (bits 8i+7..8i) is written, and only when `bw_n[i]` was 0 at edge E. Lanes with `bw_n[i]`=1 keep their old value. Write cycles leave `rvalid`=0.
- R4: The device is selected only when `{ce1_n,ce2,ce3_n}` = 3'b010. Any other value on a load cycle is a deselect: nothing is written, and the next enabled edge gives `rvalid`=0.
- R5: With `burst_mode`=0 at the load cycle, the k-th advance after the load uses low address bits (start + k) mod 4. The upper address bits stay fixed.
- R6: With `burst_mode`=1 at the load cycle, the k-th advance after the load uses low address bits start XOR (k mod 4).
- R7: An edge with `clk_en`=0 changes nothing. `rdata` and `rvalid` hold, no write is committed, and the pending write still takes its data at the next enabled edge.
- R8: Reads and writes may alternate on consecutive cycles with no idle cycle. A read loaded right after a write to the same address returns the newly written data.
- R9: On an advance cycle, `ce1_n`, `ce2`, `ce3_n`, `wr_n` and `addr` are ignored. An advance after a deselect stays deselected and writes nothing.
- R10: After the fourth address of a burst, further advances wrap to the start address and repeat the same order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of pipeline state |
| clk_en | input | 1 | Clock enable; 0 freezes the pipeline |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| adv_load | input | 1 | 0 = load new access, 1 = advance burst |
| wr_n | input | 1 | 0 = write, 1 = read (load cycles only) |
| bw_n | input | DW/8 | Active-low byte-lane write enables |
| burst_mode | input | 1 | 1 = interleaved order, 0 = linear order |
| addr | input | AW | Word address |
| wdata | input | DW | Write data, one enabled cycle after its address |
| rdata | output | DW | Read data, 0 when not valid |
| rvalid | output | 1 | Read data valid |

## Verification
The first stimulus fills every word through pipelined full-lane writes, so that each later read is compared against a known word. Directed sequences come next. Partial byte-lane masks show whether lanes are gated one by one. All seven non-selecting chip-enable codes show the decode is exact. Linear and interleaved bursts from odd and even starts, run for more than four beats, separate the two orders and check the wrap. Stalls placed inside a read and between a write's address and data check the freeze and the data alignment. Alternating write/read to the same address checks that no cycle is lost and that new data is returned. A long constrained-random run then mixes stalls, deselects, advances and mode changes against a bench-side reference model.

// File: rtl/pbsram_pkg.sv
package pbsram_pkg;

    localparam int LANE_W = 8;

    typedef enum logic [1:0] {
        ST_DESEL = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } op_st_e;

    // Low two address bits for burst beat 'step' from 'start'.
    function automatic logic [1:0] burst_lo(input logic [1:0] start,
                                            input logic [1:0] step,
                                            input logic       interleave);
        logic [1:0] r;
        if (interleave) r = start ^ step;
        else            r = start + step;
        return r;
    endfunction

endpackage

// File: rtl/pbsram_ctrl.sv
module pbsram_ctrl
    import pbsram_pkg::*;
#(
    parameter int AW = 8,
    parameter int NB = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clk_en,
    input  logic          ce1_n,
    input  logic          ce2,
    input  logic          ce3_n,
    input  logic          adv_load,
    input  logic          wr_n,
    input  logic [NB-1:0] bw_n,
    input  logic          burst_mode,
    input  logic [AW-1:0] addr,
    output op_st_e        st_q,
    output logic [AW-1:0] base_q,
    output logic [1:0]    step_q,
    output logic          mode_q,
    output logic [NB-1:0] bw_q
);

    op_st_e st_nxt;
    logic   sel;

    assign sel = !ce1_n && ce2 && !ce3_n;

    // Next-state decode: LOAD_* on adv_load=0, ADVANCE otherwise.
    always_comb begin
        st_nxt = st_q;
        if (!adv_load) begin
            if (!sel)      st_nxt = ST_DESEL;
            else if (wr_n) st_nxt = ST_READ;
            else           st_nxt = ST_WRITE;
        end else begin
            unique case (st_q)
                ST_DESEL: st_nxt = ST_DESEL;
                ST_READ:  st_nxt = ST_READ;
                ST_WRITE: st_nxt = ST_WRITE;
                default:  st_nxt = ST_DESEL;
            endcase
        end
    end

    // State register; STALL when clk_en is low.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      st_q <= ST_DESEL;
        else if (clk_en) st_q <= st_nxt;
    end

    // Burst pointer and per-beat byte enables.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            step_q <= '0;
            mode_q <= 1'b0;
            bw_q   <= '1;
        end else if (clk_en) begin
            bw_q <= bw_n;
            if (!adv_load) begin
                base_q <= addr;
                step_q <= '0;
                mode_q <= burst_mode;
            end else begin
                step_q <= step_q + 2'd1;
            end
        end
    end

endmodule

// File: rtl/pbsram_burst.sv
module pbsram_burst
    import pbsram_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic [AW-1:0] base,
    input  logic [1:0]    step,
    input  logic          interleave,
    output logic [AW-1:0] eff_addr
);

    always_comb begin
        eff_addr      = base;
        eff_addr[1:0] = burst_lo(base[1:0], step, interleave);
    end

endmodule

// File: rtl/pbsram_array.sv
module pbsram_array
    import pbsram_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  op_st_e            st,
    input  logic [AW-1:0]     eff_addr,
    input  logic [DW/LANE_W-1:0] bw_q,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    output logic              rvalid
);

    localparam int NB    = DW / LANE_W;
    localparam int DEPTH = 1 << AW;

    logic do_wr;
    logic do_rd;

    assign do_wr = clk_en && (st == ST_WRITE);
    assign do_rd = (st == ST_READ);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rvalid <= 1'b0;
        else if (clk_en) rvalid <= do_rd;
    end

    for (genvar g = 0; g < NB; g++) begin : g_lane
        logic [LANE_W-1:0] lane_mem [DEPTH];
        logic [LANE_W-1:0] lane_q;

        always_ff @(posedge clk) begin
            if (do_wr && !bw_q[g]) lane_mem[eff_addr] <= wdata[g*LANE_W +: LANE_W];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          lane_q <= '0;
            else if (clk_en) begin
                if (do_rd)       lane_q <= lane_mem[eff_addr];
                else             lane_q <= '0;
            end
        end

        assign rdata[g*LANE_W +: LANE_W] = lane_q;
    end

endmodule

// File: rtl/pbsram_top.sv
module pbsram_top
    import pbsram_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clk_en,
    input  logic                 ce1_n,
    input  logic                 ce2,
    input  logic                 ce3_n,
    input  logic                 adv_load,
    input  logic                 wr_n,
    input  logic [DW/8-1:0]      bw_n,
    input  logic                 burst_mode,
    input  logic [AW-1:0]        addr,
    input  logic [DW-1:0]        wdata,
    output logic [DW-1:0]        rdata,
    output logic                 rvalid
);

    localparam int NB = DW / LANE_W;

    op_st_e        st_q;
    logic [AW-1:0] base_q;
    logic [1:0]    step_q;
    logic          mode_q;
    logic [NB-1:0] bw_q;
    logic [AW-1:0] eff_addr;

    pbsram_ctrl #(.AW(AW), .NB(NB)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en),
        .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
        .adv_load(adv_load), .wr_n(wr_n), .bw_n(bw_n),
        .burst_mode(burst_mode), .addr(addr),
        .st_q(st_q), .base_q(base_q), .step_q(step_q),
        .mode_q(mode_q), .bw_q(bw_q)
    );

    pbsram_burst #(.AW(AW)) u_burst (
        .base(base_q), .step(step_q), .interleave(mode_q), .eff_addr(eff_addr)
    );

    pbsram_array #(.AW(AW), .DW(DW)) u_array (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .st(st_q),
        .eff_addr(eff_addr), .bw_q(bw_q), .wdata(wdata),
        .rdata(rdata), .rvalid(rvalid)
    );

endmodule

// File: rtl/pbsram_chk.sv
module pbsram_chk #(
    parameter int AW = 8,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          clk_en,
    input logic          ce1_n,
    input logic          ce2,
    input logic          ce3_n,
    input logic          adv_load,
    input logic          wr_n,
    input logic [DW-1:0] rdata,
    input logic          rvalid
);

    logic sel_in;
    assign sel_in = !ce1_n && ce2 && !ce3_n;

    // R1: invalid output is always zero
    p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !rvalid |-> (rdata == '0));

    // R2: loaded read gives valid data after the next enabled edge
    p_read_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !adv_load && sel_in && wr_n) ##1 clk_en |=> rvalid);

    // R3: loaded write never raises valid
    p_write_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !adv_load && sel_in && !wr_n) ##1 clk_en |=> !rvalid);

    // R4: deselect load never raises valid
    p_desel_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !adv_load && !sel_in) ##1 clk_en |=> !rvalid);

    // R7: stalled edge holds the outputs
    p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> ($stable(rdata) && $stable(rvalid)));

endmodule

bind pbsram_top pbsram_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en),
    .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
    .adv_load(adv_load), .wr_n(wr_n),
    .rdata(rdata), .rvalid(rvalid)
);

// File: tb/pbsram_top_tb.sv
module pbsram_top_tb;

    localparam int CLK_P = 10;
    localparam int AW    = 8;
    localparam int DW    = 32;
    localparam int NB    = DW / 8;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clk_en = 1'b1;
    logic          ce1_n = 1'b1, ce2 = 1'b0, ce3_n = 1'b1;
    logic          adv_load = 1'b0, wr_n = 1'b1;
    logic [NB-1:0] bw_n = '1;
    logic          burst_mode = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          rvalid;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;
    bit cur_md = 0;

    // reference model
    logic [DW-1:0] mm [DEPTH];
    int            m_op = 0;       // 0 desel, 1 read, 2 write
    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_step = '0;
    logic          m_mode = 1'b0;
    logic [NB-1:0] m_bw = '1;
    bit            ev = 0;
    logic [DW-1:0] ed = '0;

    localparam logic [2:0] SEL = 3'b010;

    always #(CLK_P/2) clk = ~clk;

    pbsram_top #(.AW(AW), .DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en),
        .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
        .adv_load(adv_load), .wr_n(wr_n), .bw_n(bw_n),
        .burst_mode(burst_mode), .addr(addr), .wdata(wdata),
        .rdata(rdata), .rvalid(rvalid)
    );

    function automatic logic [AW-1:0] model_addr(input logic [AW-1:0] b,
                                                 input logic [1:0] s, input logic md);
        logic [AW-1:0] r;
        r = b;
        r[1:0] = md ? (b[1:0] ^ s) : (b[1:0] + s);
        return r;
    endfunction

    function automatic logic [DW-1:0] pat(input int a);
        return 32'hA5000000 ^ (a * 32'h00010203) ^ 32'h5A;
    endfunction

    task automatic check(input string tag);
        n_chk++;
        if (rvalid !== ev || rdata !== ed) begin
            n_err++;
            $display("FAIL %s: rvalid=%0b rdata=%h expected rvalid=%0b rdata=%h",
                     tag, rvalid, rdata, ev, ed);
        end
    endtask

    task automatic step(input bit en, input logic [2:0] ce, input bit adv,
                        input bit wn, input int a, input logic [NB-1:0] bw,
                        input bit md, input logic [DW-1:0] wd, input string tag);
        logic [AW-1:0] ea;
        clk_en = en; {ce1_n, ce2, ce3_n} = ce; adv_load = adv; wr_n = wn;
        addr = a[AW-1:0]; bw_n = bw; burst_mode = md; wdata = wd;
        if (en) begin
            ea = model_addr(m_base, m_step, m_mode);
            if (m_op == 1) begin
                ev = 1; ed = mm[ea];
            end else begin
                if (m_op == 2)
                    for (int l = 0; l < NB; l++)
                        if (!m_bw[l]) mm[ea][l*8 +: 8] = wd[l*8 +: 8];
                ev = 0; ed = '0;
            end
            if (!adv) begin
                m_op = (ce == SEL) ? (wn ? 1 : 2) : 0;
                m_base = a[AW-1:0]; m_step = '0; m_mode = md;
            end else begin
                m_step = m_step + 2'd1;
            end
            m_bw = bw;
        end
        @(posedge clk);
        @(negedge clk);
        check(tag);
    endtask

    task automatic ld_rd(input int a, input logic [DW-1:0] wd, input string tag);
        step(1, SEL, 0, 1, a, '1, cur_md, wd, tag);
    endtask
    task automatic ld_wr(input int a, input logic [NB-1:0] bw, input logic [DW-1:0] wd,
                         input string tag);
        step(1, SEL, 0, 0, a, bw, cur_md, wd, tag);
    endtask
    task automatic adv(input logic [NB-1:0] bw, input logic [DW-1:0] wd, input string tag);
        step(1, 3'b111, 1, 1, 0, bw, cur_md, wd, tag);
    endtask
    task automatic desel(input logic [DW-1:0] wd, input string tag);
        step(1, 3'b100, 0, 1, 0, '1, cur_md, wd, tag);
    endtask
    task automatic stall(input logic [DW-1:0] wd, input string tag);
        step(0, SEL, 0, 0, 0, '0, cur_md, wd, tag);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: run=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'd1234);
        repeat (3) @(negedge clk);
        check("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release");

        // R3: fill array, pipelined write data
        for (int a = 0; a < DEPTH; a++)
            ld_wr(a, '0, (a == 0) ? '0 : pat(a - 1), "R3 fill");
        desel(pat(DEPTH - 1), "R3 fill tail");

        // R2: reads
        ld_rd(3, '0, "R2 read");
        ld_rd(200, '0, "R2 read");
        ld_rd(0, '0, "R2 read");
        desel('0, "R2 read");

        // R3: byte lanes 0 and 2 only (bw_n=1010)
        ld_wr(5, 4'b1010, '0, "R3 lanes");
        desel(32'h11223344, "R3 lanes");
        ld_rd(5, '0, "R3 lanes");
        desel('0, "R3 lanes");

        // R4: all non-selecting codes with a write
        for (int c = 0; c < 8; c++) begin
            if (c == 2) continue;
            step(1, c[2:0], 0, 0, 7, '0, 0, '0, "R4 desel");
            desel(32'hDEADBEEF, "R4 desel");
        end
        ld_rd(7, '0, "R4 unchanged");
        desel('0, "R4 unchanged");

        // R5 / R10: linear read from 2, six beats
        cur_md = 0;
        ld_rd(18, '0, "R5 linear");
        for (int k = 0; k < 6; k++) adv('1, '0, (k < 3) ? "R5 linear" : "R10 wrap");
        desel('0, "R10 wrap");

        // R6 / R10: interleaved read from 1, six beats
        cur_md = 1;
        ld_rd(41, '0, "R6 interleave");
        for (int k = 0; k < 6; k++) adv('1, '0, (k < 3) ? "R6 interleave" : "R10 wrap");
        desel('0, "R6 interleave");

        // R6: interleaved burst write from 3 then read back linearly
        ld_wr(99, '0, '0, "R6 burst write");
        for (int k = 0; k < 3; k++) adv('0, 32'hC0DE0000 + k, "R6 burst write");
        desel(32'hC0DE0003, "R6 burst write");
        cur_md = 0;
        ld_rd(96, '0, "R6 readback");
        for (int k = 0; k < 3; k++) adv('1, '0, "R6 readback");
        desel('0, "R6 readback");

        // R7: stall inside a read and inside a write
        ld_rd(10, '0, "R7 stall");
        stall(32'hBAD0BAD0, "R7 stall");
        stall(32'hBAD0BAD1, "R7 stall");
        desel('0, "R7 stall");
        ld_wr(11, '0, '0, "R7 stall write");
        stall(32'hBAD0BAD2, "R7 stall write");
        stall(32'hBAD0BAD3, "R7 stall write");
        desel(32'h0BADF00D, "R7 stall write");
        ld_rd(11, '0, "R7 stall write");
        desel('0, "R7 stall write");

        // R8: alternating write / read same address every cycle
        for (int k = 0; k < 6; k++) begin
            ld_wr(20 + k, '0, (k == 0) ? '0 : 32'h0, "R8 turnaround");
            ld_rd(20 + k, 32'h77000000 + k, "R8 turnaround");
        end
        ld_wr(30, '0, '0, "R8 turnaround");
        ld_rd(31, 32'h12345678, "R8 turnaround");
        ld_rd(30, '0, "R8 turnaround");
        desel('0, "R8 turnaround");

        // R9: advance after deselect with selecting enables and wr_n=0
        desel('0, "R9 adv desel");
        step(1, SEL, 1, 0, 50, '0, 0, 32'hFFFF0000, "R9 adv desel");
        step(1, SEL, 1, 0, 50, '0, 0, 32'hFFFF0001, "R9 adv desel");
        desel(32'hFFFF0002, "R9 adv desel");
        ld_rd(0, '0, "R9 adv desel");
        adv('1, '0, "R9 adv desel");
        desel('0, "R9 adv desel");
        // R9: advance in a read ignores wr_n and addr
        ld_rd(60, '0, "R9 adv read");
        step(1, 3'b000, 1, 0, 200, '0, 0, '0, "R9 adv read");
        desel('0, "R9 adv read");

        // random mix
        for (int i = 0; i < 4000; i++) begin
            logic [2:0] ce;
            ce = (($urandom % 10) < 8) ? SEL : 3'($urandom);
            step(($urandom % 8) != 0, ce, ($urandom % 3) == 0, $urandom % 2,
                 $urandom % DEPTH, 4'($urandom), $urandom % 2, $urandom, "R2 random");
        end

        done = 1;
        summary();
        $finish;
    end

endmodule